// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital timing core of a successive-approximation converter. It divides the system clock by a selectable power of two to make a slow converter clock. It lines each conversion up with a rising edge of that clock. It then marks two moments at fixed offsets from the start: a sample-and-hold strobe half-way through the second converter cycle, and a completion strobe thirteen converter cycles after the start. On the completion strobe the result presented on `result_in` is captured. The comparator, the DAC and the register file that software reads are outside this block.

Software writes a start request. The block reports busy from the cycle after that write until the conversion ends. In single mode the block then waits one converter cycle of recovery before it can convert again. In free-run mode it restarts on the completion edge itself. The channel number is sampled only when a conversion begins, so a change made mid-conversion is deferred. Dropping `enable` clears the prescaler and aborts any conversion.

The controller has four states:
- SEQ_IDLE: nothing pending.
- SEQ_ARMED: a start was accepted and the block is waiting for the next converter rising edge.
- SEQ_CONVERT: a conversion is running, and a cycle counter counts converter rising edges.
- SEQ_RECOVER: the single-mode gap after a result.

The transitions are:
- idle to armed on a start write.
- armed to convert on a rising tick.
- convert to convert on the final tick when free-run is set, which restarts the conversion.
- convert to recover on the final tick in single mode.
- recover to convert on a tick when a start is pending or arrives in that cycle.
- recover to idle on a tick with no start.
- any state to idle whenever `enable` is low.

Top module: `adc_conv_sequencer`

## Requirements
In the requirements below, D is the divisor and edge numbers count system clock edges at which `enable` is high. Edge 1 is the first such edge after `enable` was low.
- R1: While `enable` is low the prescaler count is held at zero. Converter rising edges fall on edges D, 2D, 3D, and so on. The mid-cycle falling points fall on edges D/2 + mD.
- R2: `div_sel` codes 0 and 1 give D = 2. A code c of 2 or more gives D = 2^c, so codes 2 through 7 give 4 through 128.
- R3: A `start_wr` pulse seen in idle with `enable` high raises `busy` from the next cycle. The conversion starts (edge t0) at the first converter rising edge after the write, and `busy` stays high throughout.
- R4: `sample_stb` is high for exactly the one system cycle that follows edge t0 + 3D/2.
- R5: `done_stb` is high for exactly the one cycle that follows edge t0 + 13D. From that cycle `result_out` holds the value `result_in` had at that edge. In single mode `busy` falls in that cycle.
- R6: `active_chan` loads `chan_req` only at a conversion start edge. A change of `chan_req` during a conversion first shows at the next start.
- R7: In single mode, a start written during the recovery cycle raises `busy` again. The new conversion then starts at edge t0 + 14D. Without such a write the block returns to idle at that edge.
- R8: With `free_run` high at the completion edge, the next conversion starts at that same edge, which becomes the new t0, and `active_chan` reloads.
- R9: `enable` low at an edge aborts any conversion: `busy` is low from the next cycle and no strobe follows. `start_wr` pulses while `enable` is low are ignored.
- R10: `start_wr` pulses while armed or converting change neither timing nor state.
- R11: After reset `busy`, both strobes, `active_chan` and `result_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter enable; low clears prescaler and aborts |
| div_sel | input | 3 | Prescale select code |
| start_wr | input | 1 | One-cycle start request write strobe |
| free_run | input | 1 | 1 = free-run restart, 0 = single conversion |
| chan_req | input | 3 | Requested channel number |
| result_in | input | 10 | Conversion result from the data path |
| busy | output | 1 | Start/busy status bit |
| sample_stb | output | 1 | Sample-and-hold strobe, one cycle wide |
| done_stb | output | 1 | Result-write strobe, one cycle wide |
| active_chan | output | 3 | Channel of the current or last conversion |
| result_out | output | 10 | Result captured at the write strobe |

## Verification
The bench measures the first sample edge from the moment `enable` rises, for every select code. A prescaler that keeps counting while disabled, or that maps codes 0 and 1 wrongly, moves that edge or stretches the sample-to-done gap. Channel changes are made after the sample strobe, so a design that loads the channel continuously reports the new channel too early. Starts written during recovery must begin exactly one converter cycle after completion; a design that drops them, or starts them at once, shifts the next sample. Free-run spacing must be exactly 13 converter cycles, and disabling mid-conversion must kill the pending completion strobe rather than let it appear late.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
package adcseq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ARMED   = 2'd1,
        SEQ_CONVERT = 2'd2,
        SEQ_RECOVER = 2'd3
    } seq_state_t;

    // Shift amount (log2 of divisor) for a select code; codes below 1 alias to 1
    function automatic int code_shift(input int code, input int max_sh);
        int sh;
        sh = (code < 1) ? 1 : code;
        if (sh > max_sh) sh = max_sh;
        return sh;
    endfunction

endpackage

// File: rtl/adcseq_prescaler.sv
`timescale 1ns/1ps
module adcseq_prescaler #(
    parameter int PRE_W = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [SEL_W-1:0] div_sel,
    output logic             rise_tick,
    output logic             fall_tick
);
    localparam int N_CODES = 1 << SEL_W;

    logic [PRE_W-1:0] count;
    logic [PRE_W-1:0] mask_tbl [N_CODES];
    logic [PRE_W-1:0] sel_mask;
    logic [PRE_W-1:0] half_mask;

    // One low-bit mask per select code, computed at elaboration
    generate
        for (genvar c = 0; c < N_CODES; c++) begin : g_mask
            localparam int SH = adcseq_pkg::code_shift(c, PRE_W);
            assign mask_tbl[c] = PRE_W'((32'd1 << SH) - 32'd1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!enable) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end

    always_comb begin
        sel_mask  = mask_tbl[div_sel];
        half_mask = sel_mask >> 1;
        rise_tick = enable && ((count & sel_mask) == sel_mask);
        fall_tick = enable && ((count & sel_mask) == half_mask);
    end

    // R1: counter cleared whenever enable was low at the previous edge
    a_r1_held_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0));

    // R1: a rising point and a falling point never coincide
    a_r1_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |-> !fall_tick);

endmodule

// File: rtl/adcseq_ctrl.sv
`timescale 1ns/1ps
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int CONV_CYCLES = 13,
    parameter int SAMPLE_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic start_wr,
    input  logic free_run,
    input  logic rise_tick,
    input  logic fall_tick,
    output logic busy,
    output logic sample_stb,
    output logic done_stb,
    output logic load_chan,
    output logic capture_res
);
    localparam int          CYC_W = $clog2(CONV_CYCLES);
    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(CONV_CYCLES - 1);
    localparam logic [CYC_W-1:0] SAMP_CYC = CYC_W'(SAMPLE_CYC);

    seq_state_t       state, state_nx;
    logic [CYC_W-1:0] cyc, cyc_nx;
    logic             pend, pend_nx;
    logic             sample_hit;

    // Next-state and event decode
    always_comb begin
        state_nx    = state;
        cyc_nx      = cyc;
        pend_nx     = pend;
        load_chan   = 1'b0;
        capture_res = 1'b0;
        sample_hit  = 1'b0;
        if (!enable) begin
            state_nx = SEQ_IDLE;
            pend_nx  = 1'b0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start_wr) state_nx = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (rise_tick) begin
                        state_nx  = SEQ_CONVERT;
                        cyc_nx    = '0;
                        load_chan = 1'b1;
                    end
                end
                SEQ_CONVERT: begin
                    if (fall_tick && (cyc == SAMP_CYC)) sample_hit = 1'b1;
                    if (rise_tick) begin
                        if (cyc == LAST_CYC) begin
                            capture_res = 1'b1;
                            if (free_run) begin
                                cyc_nx    = '0;
                                load_chan = 1'b1;
                            end else begin
                                state_nx = SEQ_RECOVER;
                                pend_nx  = 1'b0;
                            end
                        end else begin
                            cyc_nx = cyc + 1'b1;
                        end
                    end
                end
                SEQ_RECOVER: begin
                    if (rise_tick) begin
                        pend_nx = 1'b0;
                        if (pend || start_wr) begin
                            state_nx  = SEQ_CONVERT;
                            cyc_nx    = '0;
                            load_chan = 1'b1;
                        end else begin
                            state_nx = SEQ_IDLE;
                        end
                    end else if (start_wr) begin
                        pend_nx = 1'b1;
                    end
                end
                default: state_nx = SEQ_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            cyc   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= state_nx;
            cyc   <= cyc_nx;
            pend  <= pend_nx;
        end
    end

    // Registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            done_stb   <= 1'b0;
        end else begin
            sample_stb <= sample_hit;
            done_stb   <= capture_res;
        end
    end

    assign busy = (state == SEQ_ARMED) || (state == SEQ_CONVERT) ||
                  ((state == SEQ_RECOVER) && pend);

    a_r4_sample_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    a_r5_done_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
        done_stb |=> !done_stb);

    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_wr && state == SEQ_IDLE) |=> busy);

    a_r9_disable_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && state == SEQ_IDLE));

    a_r8_freerun_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && capture_res && free_run) |=> (state == SEQ_CONVERT && cyc == '0));

    a_r7_recover_after_single: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && capture_res && !free_run) |=> (state == SEQ_RECOVER));

endmodule

// File: rtl/adcseq_capture.sv
`timescale 1ns/1ps
module adcseq_capture #(
    parameter int CHAN_W = 3,
    parameter int RES_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_chan,
    input  logic              capture_res,
    input  logic [CHAN_W-1:0] chan_req,
    input  logic [RES_W-1:0]  result_in,
    output logic [CHAN_W-1:0] active_chan,
    output logic [RES_W-1:0]  result_out
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_chan <= '0;
        end else if (load_chan) begin
            active_chan <= chan_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_out <= '0;
        end else if (capture_res) begin
            result_out <= result_in;
        end
    end

endmodule

// File: rtl/adc_conv_sequencer.sv
`timescale 1ns/1ps
module adc_conv_sequencer #(
    parameter int PRE_W       = 7,
    parameter int SEL_W       = 3,
    parameter int CHAN_W      = 3,
    parameter int RES_W       = 10,
    parameter int CONV_CYCLES = 13,
    parameter int SAMPLE_CYC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [SEL_W-1:0]  div_sel,
    input  logic              start_wr,
    input  logic              free_run,
    input  logic [CHAN_W-1:0] chan_req,
    input  logic [RES_W-1:0]  result_in,
    output logic              busy,
    output logic              sample_stb,
    output logic              done_stb,
    output logic [CHAN_W-1:0] active_chan,
    output logic [RES_W-1:0]  result_out
);
    logic rise_tick;
    logic fall_tick;
    logic load_chan;
    logic capture_res;

    adcseq_prescaler #(
        .PRE_W (PRE_W),
        .SEL_W (SEL_W)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .div_sel   (div_sel),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    adcseq_ctrl #(
        .CONV_CYCLES (CONV_CYCLES),
        .SAMPLE_CYC  (SAMPLE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .start_wr    (start_wr),
        .free_run    (free_run),
        .rise_tick   (rise_tick),
        .fall_tick   (fall_tick),
        .busy        (busy),
        .sample_stb  (sample_stb),
        .done_stb    (done_stb),
        .load_chan   (load_chan),
        .capture_res (capture_res)
    );

    adcseq_capture #(
        .CHAN_W (CHAN_W),
        .RES_W  (RES_W)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_chan   (load_chan),
        .capture_res (capture_res),
        .chan_req    (chan_req),
        .result_in   (result_in),
        .active_chan (active_chan),
        .result_out  (result_out)
    );

    // R6: channel only moves on a conversion start
    a_r6_chan_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        !load_chan |=> $stable(active_chan));

    // R5: result only moves together with the completion strobe
    a_r5_result_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_out) |-> done_stb);

endmodule

// File: tb/test_adc_conv_sequencer.sv
`timescale 1ns/1ps
module test_adc_conv_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       start_wr = 1'b0;
    logic       free_run = 1'b0;
    logic [2:0] chan_req = 3'd0;
    logic [9:0] result_in = 10'd0;
    logic       busy, sample_stb, done_stb;
    logic [2:0] active_chan;
    logic [9:0] result_out;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_conv_sequencer i_adc_conv_sequencer (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_sel(div_sel),
        .start_wr(start_wr), .free_run(free_run), .chan_req(chan_req),
        .result_in(result_in), .busy(busy), .sample_stb(sample_stb),
        .done_stb(done_stb), .active_chan(active_chan), .result_out(result_out)
    );

    // ---------------- behavioural reference model ----------------
    int  pc = 0, ph = 0, k = 0, edgecnt = 0;
    bit  pend = 0;
    bit  m_busy = 0, m_samp = 0, m_done = 0;
    int  m_chan = 0, m_res = 0;

    function automatic int divisor(input int code);
        return (code < 2) ? 2 : (1 << code);
    endfunction

    always @(posedge clk) begin
        int d;
        bit rise, fall;
        edgecnt++;
        if (!rst_n) begin
            pc = 0; ph = 0; k = 0; pend = 0;
            m_samp = 0; m_done = 0; m_chan = 0; m_res = 0;
        end else begin
            d = divisor(int'(div_sel));
            rise = enable && (pc % d == d - 1);
            fall = enable && (pc % d == d / 2 - 1);
            m_samp = 0; m_done = 0;
            if (!enable) begin
                ph = 0; pend = 0;
            end else if (ph == 0) begin
                if (start_wr) ph = 1;
            end else if (ph == 1) begin
                if (rise) begin ph = 2; k = 0; m_chan = int'(chan_req); end
            end else if (ph == 2) begin
                if (fall && k == 1) m_samp = 1;
                if (rise) begin
                    if (k == 12) begin
                        m_done = 1; m_res = int'(result_in);
                        if (free_run) begin k = 0; m_chan = int'(chan_req); end
                        else begin ph = 3; pend = 0; end
                    end else k++;
                end
            end else begin
                if (rise) begin
                    if (pend || start_wr) begin ph = 2; k = 0; m_chan = int'(chan_req); end
                    else ph = 0;
                    pend = 0;
                end else if (start_wr) pend = 1;
            end
            pc = enable ? (pc + 1) % 128 : 0;
        end
        m_busy = (ph == 1) || (ph == 2) || (ph == 3 && pend);
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison and event recording
    int samp_edge = 0, done_edge = 0, samp_count = 0, done_count = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == m_busy, "R3 busy", busy, m_busy);
            check(sample_stb == m_samp, "R4 sample_stb", sample_stb, m_samp);
            check(done_stb == m_done, "R5 done_stb", done_stb, m_done);
            check(int'(result_out) == m_res, "R5 result_out", result_out, m_res);
            check(int'(active_chan) == m_chan, "R6 active_chan", active_chan, m_chan);
            if (sample_stb) begin samp_edge = edgecnt; samp_count++; end
            if (done_stb)   begin done_edge = edgecnt; done_count++; end
        end
    end

    initial forever begin
        @(negedge clk);
        result_in = result_in + 10'd37;
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic pulse_start();
        start_wr = 1'b1; step(); start_wr = 1'b0;
    endtask

    task automatic wait_samp();
        int c0 = samp_count;
        while (samp_count == c0) step();
    endtask

    task automatic wait_done();
        int c0 = done_count;
        while (done_count == c0) step();
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int e0, d, s_at, d1, c0;
        step(4);
        // R11: reset state
        check(busy == 0 && sample_stb == 0 && done_stb == 0, "R11 reset strobes/busy",
              int'({busy, sample_stb, done_stb}), 0);
        check(active_chan == 0 && result_out == 0, "R11 reset chan/result",
              int'(active_chan) + int'(result_out), 0);
        rst_n = 1'b1;
        step(3);

        // R1/R2: every select code, timed from enable rising
        for (int code = 0; code < 8; code++) begin
            d = divisor(code);
            enable = 1'b0; div_sel = 3'(code); step(5);
            e0 = edgecnt;
            enable = 1'b1; start_wr = 1'b1; step(); start_wr = 1'b0;
            wait_samp();
            check(samp_edge - e0 == 5 * d / 2, "R1 first sample edge", samp_edge - e0, 5 * d / 2);
            s_at = samp_edge;
            wait_done();
            check(done_edge - s_at == 23 * d / 2, "R2 sample-to-done span", done_edge - s_at, 23 * d / 2);
            step(2);
            check(busy == 0, "R5 busy clear after single", busy, 0);
        end

        // R6 / R10: deferred channel change, ignored re-start
        div_sel = 3'd2; d = 4; chan_req = 3'd3;
        step(2 * d);
        pulse_start();
        wait_samp();
        s_at = samp_edge;
        chan_req = 3'd5;
        pulse_start();                  // R10: ignored while converting
        wait_done();
        check(done_edge - s_at == 23 * d / 2, "R10 restart ignored", done_edge - s_at, 23 * d / 2);
        check(active_chan == 3'd3, "R6 channel held", active_chan, 3);

        // R7: start during recovery starts one converter cycle later
        step();
        pulse_start();
        check(busy == 1, "R7 busy during pending recovery", busy, 1);
        d1 = done_edge;
        wait_samp();
        check(samp_edge - d1 == 5 * d / 2, "R7 restart after recovery", samp_edge - d1, 5 * d / 2);
        check(active_chan == 3'd5, "R6 channel at next start", active_chan, 5);
        wait_done();
        step(2 * d);

        // R8: free-run back-to-back conversions
        free_run = 1'b1; chan_req = 3'd6;
        pulse_start();
        wait_done();
        d1 = done_edge;
        chan_req = 3'd1;
        wait_done();
        check(done_edge - d1 == 13 * d, "R8 free-run spacing", done_edge - d1, 13 * d);
        d1 = done_edge;
        wait_samp();
        check(samp_edge - d1 == 3 * d / 2, "R8 immediate restart", samp_edge - d1, 3 * d / 2);
        check(active_chan == 3'd1, "R8 channel reload", active_chan, 1);
        free_run = 1'b0;
        wait_done();
        step(2 * d);

        // R9: abort and ignored starts while disabled
        pulse_start();
        wait_samp();
        c0 = done_count;
        enable = 1'b0;
        step(2);
        check(busy == 0, "R9 busy cleared on disable", busy, 0);
        pulse_start();
        step(2);
        check(busy == 0, "R9 start ignored while disabled", busy, 0);
        enable = 1'b1;
        step(20 * d);
        check(done_count == c0, "R9 no completion after abort", done_count, c0);
        check(busy == 0, "R9 still idle after re-enable", busy, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule